// File: doc/BRIEF.md
# GPIO Port Interrupt Controller

This block controls three 8-bit general purpose I/O ports, called A, B and F. Each port has an output value register and a direction register that drive the pads. Pad inputs pass through a two-flop synchronizer. An optional per-line debounce filter can follow the synchronizer. A line can raise an interrupt on a level or on an edge, and the polarity is selectable.

A status bit shows each line's interrupt state. A latched edge stays set until software writes a one to that line's end-of-interrupt bit. The status bits of ports A and B are combined into a single shared request. Port F gives each of its eight lines its own request output. Hardware has no mode that fires on both edges. Software gets that behaviour by flipping the polarity bit after each event.

Configuration uses a simple synchronous bus. A write takes effect on the clock edge on which `bus_we` is high. A read is combinational from `bus_addr`.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every configuration register reads 0, `pad_oe` and `pad_out` are 0, and `irq_ab` and `irq_f` are 0.
- R2: A direction bit of 1 makes the line an output: `pad_oe` follows the direction register and `pad_out` follows the output register. A read of a port's data address returns the output register bit for output lines. For input lines it returns the pad value after the two synchronizer flops.
- R3: With the edge-select bit at 0 (level mode), an enabled line's status is 1 while its qualified input equals the polarity bit (1 = high active, 0 = low active). End-of-interrupt writes have no effect on it.
- R4: With the edge-select bit at 1 (edge mode), an enabled line's status is set by a rising edge when the polarity bit is 1, or by a falling edge when it is 0. The opposite edge does not set it, and the bit stays set afterwards.
- R5: Writing 1 to an end-of-interrupt bit clears that line's latched edge, and 0 bits leave the line alone. If a new edge arrives in the same cycle as the clear, the new edge wins.
- R6: A line whose enable bit is 0 has status 0 and never latches an edge. Clearing the enable drops a latched edge. Setting the enable again does not revive an edge that happened while it was off.
- R7: Writing the edge-select or polarity bits while the input is steady never produces a latched edge.
- R8: With the debounce bit set, a new input value is accepted only after it has been seen on 4 consecutive clock samples, so shorter pulses are ignored. Without it, the qualified value follows the synchronized input one clock later.
- R9: `irq_ab` is the OR of all port A and port B status bits. `irq_f[i]` equals port F status bit i.
- R10: Register offsets (byte addresses, A/B/F): data 00/04/30, direction 10/14/34, edge-select 90/AC/4C, polarity 94/B0/50, end-of-interrupt 98/B4/54 (write only, reads 0), enable 9C/B8/58, status A0/BC/5C (read only), debounce A8/C4/64. Pad bits 7:0 belong to A, 15:8 to B and 23:16 to F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| pad_in | input | 24 | Pad input levels (F, B, A from MSB down) |
| pad_out | output | 24 | Pad output values |
| pad_oe | output | 24 | Pad output enables |
| irq_ab | output | 1 | Shared request for ports A and B |
| irq_f | output | 8 | Per-line requests for port F |

## Verification
The bench lines up an end-of-interrupt write with the cycle in which a fresh edge arrives. A design that lets the clear win there would silently lose an interrupt. It sends a three-cycle pulse into a debounced line and then counts the exact cycle in which a held level is accepted. An off-by-one filter would either pass the glitch or accept the level a cycle early or late. It also flips polarity on a steady line and toggles lines while they are disabled. A detector that compared against the configured level rather than the previous sample would fabricate a pending edge in these cases. So would one that kept latching while disabled.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int DB_LEN = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic [23:0] pad_in,
  output logic [23:0] pad_out,
  output logic [23:0] pad_oe,
  output logic        irq_ab,
  output logic [7:0]  irq_f
);
  localparam int NP = 3;
  localparam int NL = 8 * NP;
  localparam int CW = (DB_LEN > 2) ? $clog2(DB_LEN) : 1;

  localparam logic [23:0] O_DATA = {8'h30, 8'h04, 8'h00};
  localparam logic [23:0] O_DIR  = {8'h34, 8'h14, 8'h10};
  localparam logic [23:0] O_SEL  = {8'h4C, 8'hAC, 8'h90};
  localparam logic [23:0] O_POL  = {8'h50, 8'hB0, 8'h94};
  localparam logic [23:0] O_EOI  = {8'h54, 8'hB4, 8'h98};
  localparam logic [23:0] O_EN   = {8'h58, 8'hB8, 8'h9C};
  localparam logic [23:0] O_STAT = {8'h5C, 8'hBC, 8'hA0};
  localparam logic [23:0] O_DB   = {8'h64, 8'hC4, 8'hA8};

  logic [NL-1:0] dir_q, out_q, sel_q, pol_q, en_q, db_q;
  logic [NL-1:0] s1, s2, qual, prev, lat, eoi_w, edge_hit, status;

  always_comb begin
    eoi_w = '0;
    for (int p = 0; p < NP; p++)
      if (bus_we && bus_addr == O_EOI[8*p +: 8]) eoi_w[8*p +: 8] = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0; out_q <= '0; sel_q <= '0;
      pol_q <= '0; en_q  <= '0; db_q  <= '0;
    end else if (bus_we) begin
      for (int p = 0; p < NP; p++) begin
        if (bus_addr == O_DATA[8*p +: 8]) out_q[8*p +: 8] <= bus_wdata;
        if (bus_addr == O_DIR[8*p +: 8])  dir_q[8*p +: 8] <= bus_wdata;
        if (bus_addr == O_SEL[8*p +: 8])  sel_q[8*p +: 8] <= bus_wdata;
        if (bus_addr == O_POL[8*p +: 8])  pol_q[8*p +: 8] <= bus_wdata;
        if (bus_addr == O_EN[8*p +: 8])   en_q[8*p +: 8]  <= bus_wdata;
        if (bus_addr == O_DB[8*p +: 8])   db_q[8*p +: 8]  <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; prev <= '0; lat <= '0;
    end else begin
      s1   <= pad_in;
      s2   <= s1;
      prev <= qual;
      lat  <= en_q & sel_q & ((lat & ~eoi_w) | edge_hit);
    end
  end

  for (genvar i = 0; i < NL; i++) begin : g_line
    logic [CW-1:0] cnt;
    logic          q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt <= '0; q <= 1'b0;
      end else if (!db_q[i]) begin
        cnt <= '0; q <= s2[i];
      end else if (s2[i] == q) begin
        cnt <= '0;
      end else if (cnt == CW'(DB_LEN - 1)) begin
        cnt <= '0; q <= s2[i];
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
    assign qual[i] = q;
  end

  assign edge_hit = sel_q & ((pol_q & qual & ~prev) | (~pol_q & ~qual & prev));
  assign status   = (sel_q & lat) | (~sel_q & en_q & ~(qual ^ pol_q));

  assign pad_out = out_q;
  assign pad_oe  = dir_q;
  assign irq_ab  = |status[15:0];
  assign irq_f   = status[23:16];

  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NP; p++) begin
      if (bus_addr == O_DATA[8*p +: 8])
        bus_rdata = (dir_q[8*p +: 8] & out_q[8*p +: 8]) | (~dir_q[8*p +: 8] & s2[8*p +: 8]);
      if (bus_addr == O_DIR[8*p +: 8])  bus_rdata = dir_q[8*p +: 8];
      if (bus_addr == O_SEL[8*p +: 8])  bus_rdata = sel_q[8*p +: 8];
      if (bus_addr == O_POL[8*p +: 8])  bus_rdata = pol_q[8*p +: 8];
      if (bus_addr == O_EN[8*p +: 8])   bus_rdata = en_q[8*p +: 8];
      if (bus_addr == O_STAT[8*p +: 8]) bus_rdata = status[8*p +: 8];
      if (bus_addr == O_DB[8*p +: 8])   bus_rdata = db_q[8*p +: 8];
    end
  end

  p_dir_drives_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 8'h10) |=> (pad_oe[7:0] == $past(bus_wdata)));

  p_eoi_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 8'h54) |=>
      ((lat[23:16] & $past(bus_wdata) & ~$past(edge_hit[23:16])) == 8'h00));

  p_latch_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((lat & ~$past(en_q)) == '0));

  p_no_false_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((lat & ~$past(lat) & ~$past(qual ^ prev)) == '0));

  p_nodb_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (((qual ^ $past(s2)) & ~$past(db_q)) == '0));
endmodule

// File: tb/tb_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_irq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata, irq_f;
  logic [23:0] pad_in = '0, pad_out, pad_oe;
  logic irq_ab;
  int checks = 0, fails = 0;
  bit done = 0;

  gpio_irq_ctrl dut (.clk, .rst_n, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
                     .pad_in, .pad_out, .pad_oe, .irq_ab, .irq_f);

  always #2.5 clk = ~clk;

  // {polarity, pad A, expected status A}, level mode, all lines enabled
  localparam logic [23:0] LVL [0:5] = '{24'h00_00_FF, 24'hFF_FF_FF, 24'hFF_00_00,
                                        24'h0F_3C_CC, 24'hAA_55_00, 24'hF0_F0_FF};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1; bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    cyc(2); rst_n = 1'b1; cyc(1);
    chk("R1 pad_oe", pad_oe, 0); chk("R1 pad_out", pad_out, 0);
    chk("R1 irq_ab", irq_ab, 0); chk("R1 irq_f", irq_f, 0);
    rd(8'h90, v); chk("R1 sel A", v, 0);
    rd(8'h58, v); chk("R1 en F", v, 0);

    // R3 level mode via vector table
    wr(8'h9C, 8'hFF);
    for (int k = 0; k < 6; k++) begin
      wr(8'h94, LVL[k][23:16]);
      @(negedge clk); pad_in[7:0] = LVL[k][15:8];
      cyc(4);
      wr(8'h98, 8'hFF);
      rd(8'hA0, v); chk("R3 level status", v, LVL[k][7:0]);
      chk("R9 irq_ab level", irq_ab, |LVL[k][7:0]);
    end
    wr(8'h9C, 8'h00);
    @(negedge clk); pad_in[7:0] = 8'h30;

    // R2 direction and data
    wr(8'h10, 8'h0F); wr(8'h00, 8'hA5);
    chk("R2 pad_oe", pad_oe[7:0], 8'h0F); chk("R2 pad_out", pad_out[7:0], 8'hA5);
    cyc(3);
    rd(8'h00, v); chk("R2 data read mix", v, 8'h35);

    // R10 address map readback
    wr(8'h94, 8'h5A); rd(8'h94, v); chk("R10 pol A", v, 8'h5A);
    wr(8'hC4, 8'h3C); rd(8'hC4, v); chk("R10 db B", v, 8'h3C);
    wr(8'hC4, 8'h00);
    rd(8'h98, v); chk("R10 eoi reads zero", v, 0);

    // R4/R5 edge mode on port F
    wr(8'h4C, 8'hFF); wr(8'h50, 8'h0F); wr(8'h58, 8'hFF);
    cyc(4); chk("R4 no event idle", irq_f, 0);
    @(negedge clk); pad_in[18] = 1'b1; cyc(5);
    chk("R4 rising latched", irq_f, 8'h04);
    rd(8'h5C, v); chk("R9 status F matches", v, 8'h04);
    @(negedge clk); pad_in[18] = 1'b0; cyc(5);
    chk("R4 held after opposite edge", irq_f, 8'h04);
    wr(8'h54, 8'h00); cyc(1); chk("R5 zero eoi no effect", irq_f, 8'h04);
    wr(8'h54, 8'h04); cyc(1); chk("R5 eoi clears", irq_f, 8'h00);
    @(negedge clk); pad_in[21] = 1'b1; cyc(5);
    chk("R4 rise ignored on falling line", irq_f, 8'h00);
    @(negedge clk); pad_in[21] = 1'b0; cyc(5);
    chk("R4 falling latched", irq_f, 8'h20);
    wr(8'h54, 8'h20); cyc(1); chk("R5 eoi clears falling", irq_f, 8'h00);

    // R5 clear and new edge in same cycle
    @(negedge clk); pad_in[17] = 1'b1; cyc(5);
    chk("R4 line1 latched", irq_f, 8'h02);
    @(negedge clk); pad_in[17] = 1'b0; cyc(5);
    @(negedge clk); pad_in[17] = 1'b1;
    repeat (3) @(posedge clk);
    wr(8'h54, 8'h02); cyc(1);
    chk("R5 new edge beats eoi", irq_f, 8'h02);
    wr(8'h54, 8'h02); cyc(1); chk("R5 cleared after", irq_f, 8'h00);

    // R7 polarity change on steady high input
    @(negedge clk); pad_in[22] = 1'b1; cyc(5);
    wr(8'h50, 8'h4F); cyc(4); chk("R7 pol flip no edge", irq_f, 8'h00);
    wr(8'h4C, 8'h00); wr(8'h4C, 8'hFF); cyc(4);
    chk("R7 sel toggle no edge", irq_f, 8'h00);

    // R6 enable gating
    wr(8'h58, 8'h00);
    @(negedge clk); pad_in[16] = 1'b1; cyc(5);
    chk("R6 disabled no status", irq_f, 8'h00);
    wr(8'h58, 8'hFF); cyc(3); chk("R6 no revive on enable", irq_f, 8'h00);
    @(negedge clk); pad_in[17] = 1'b0; cyc(5);
    @(negedge clk); pad_in[17] = 1'b1; cyc(5);
    chk("R6 edge latched when enabled", irq_f, 8'h02);
    wr(8'h58, 8'hFD); cyc(1); chk("R6 disable drops latch", irq_f, 8'h00);
    wr(8'h58, 8'hFF); cyc(2); chk("R6 reenable stays clear", irq_f, 8'h00);

    // R8 debounce on port B line 0, level high
    wr(8'hAC, 8'h00); wr(8'hB0, 8'h01); wr(8'hC4, 8'h01); wr(8'hB8, 8'h01);
    cyc(8); chk("R8 idle low", irq_ab, 0);
    @(negedge clk); pad_in[8] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); pad_in[8] = 1'b0; cyc(10);
    chk("R8 short pulse ignored", irq_ab, 0);
    @(negedge clk); pad_in[8] = 1'b1; cyc(5);
    chk("R8 not yet accepted", irq_ab, 0);
    cyc(1); chk("R8 accepted on 4th sample", irq_ab, 1);
    rd(8'hBC, v); chk("R9 status B", v, 8'h01);
    wr(8'hC4, 8'h00);
    @(negedge clk); pad_in[8] = 1'b0; cyc(2);
    chk("R8 no debounce low after sync", irq_ab, 1);
    cyc(1); chk("R8 no debounce follows", irq_ab, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule